// File: doc/BRIEF.md
# LCD Pixel Word Unpacker

This block sits between a word FIFO and a display pipeline. It accepts 32-bit memory words over a valid/ready handshake. It cuts each word into pixels and hands out one pixel per accepted output cycle, also over valid/ready. A 3-bit depth selector sets how wide each pixel is, and therefore how many pixels one word yields.

Two independent order controls set the extraction sequence. One reverses the byte order inside the word before any pixel is cut. The other chooses whether the first pixel sits at the low or the high end of the word. Pixels of 16 and 24 bits are widened to 8-bit red, green and blue, and a swap control can exchange red and blue. Pixels of 1, 4 and 8 bits leave as raw palette indices.

A depth code that is reserved, or that is not allowed in the current panel type, raises an error flag. While the flag is high the block neither takes nor emits anything. Palette lookup, memory fetch and panel timing are handled elsewhere.

Top module: `lcd_pix_unpack`

## Requirements
- R1: The depth code selects the pixels per word: 000 gives 32 pixels of 1 bit, 010 gives 8 of 4 bits, 011 gives 4 of 8 bits, 100 and 110 give 2 of 16 bits, and 101 gives 1 pixel of 24 bits. Each accepted word produces exactly that many output pixels.
- R2: cfg_err is high, and in_ready and out_valid are both low, whenever the depth code is 001 or 111, or is 101 with cfg_tft low. A word already held is kept and resumes unchanged once the configuration is legal again.
- R3: With cfg_byte_be=1, byte i of the input word (bits 8i+7:8i) is moved to byte 3-i before pixels are cut. With cfg_byte_be=0 the word is used as received.
- R4: With cfg_pix_msb=0, pixel k of a word occupies bits k*bpp upward. With cfg_pix_msb=1, pixel k occupies the bpp bits ending at bit 31-k*bpp.
- R5: In the 1, 4 and 8 bit modes, out_pixel is the raw field, zero-extended to 24 bits. cfg_bgr has no effect in these modes.
- R6: In mode 110 (5:6:5), red is field bits 15:11, green is bits 10:5 and blue is bits 4:0. Each component is widened to 8 bits by appending its own top bits.
- R7: In mode 100 (1:5:5:5), field bit 15 is ignored. Red is bits 14:10, green is bits 9:5 and blue is bits 4:0, each widened to 8 bits by appending its top 3 bits.
- R8: In mode 101, the pixel is bits 23:0 of the byte-ordered word, and bits 31:24 are ignored.
- R9: out_pixel carries red in 23:16, green in 15:8 and blue in 7:0. In the 16 and 24 bit modes, cfg_bgr=1 exchanges the red and blue bytes.
- R10: While out_valid is high and out_ready is low, out_pixel is held. in_ready is high only when no word is held, or when the last pixel of the held word is taken in that same cycle. Pixels therefore stream without gaps while input is available.
- R11: During and right after reset, out_valid is low. With a legal configuration, in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_depth | input | 3 | Pixel depth code |
| cfg_tft | input | 1 | Panel type; allows the 24-bit mode when set |
| cfg_byte_be | input | 1 | Byte order within the word (1 = reversed) |
| cfg_pix_msb | input | 1 | Pixel order (1 = first pixel at the high end) |
| cfg_bgr | input | 1 | Exchange the red and blue output bytes |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input memory word |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| out_valid | output | 1 | Output pixel valid |
| out_pixel | output | 24 | Pixel: index or widened RGB |
| out_ready | input | 1 | Downstream takes the pixel |
| cfg_err | output | 1 | Illegal configuration |

## Verification
The bench builds the block with its default 32-bit word and 24-bit pixel. At that size it can sweep every legal depth code against every setting of byte order, pixel order and colour swap, using pseudo-random words. Each of those combinations runs once with a free-flowing output and once with periodic stalls and input gaps. This covers gap-free streaming across word boundaries as well as held pixels. Directed steps drive each illegal code, including the 24-bit mode with the panel-type bit clear, and drop to an illegal code in the middle of a word to show the held word resumes intact.

// File: rtl/lcd_unpack_pkg.sv
package lcd_unpack_pkg;

  typedef enum logic [2:0] {
    DEP_1    = 3'b000,
    DEP_RSV1 = 3'b001,
    DEP_4    = 3'b010,
    DEP_8    = 3'b011,
    DEP_1555 = 3'b100,
    DEP_24   = 3'b101,
    DEP_565  = 3'b110,
    DEP_RSV7 = 3'b111
  } depth_e;

  // Width of one pixel field in bits; zero for reserved codes.
  function automatic logic [5:0] depth_bits(depth_e d);
    case (d)
      DEP_1:    depth_bits = 6'd1;
      DEP_4:    depth_bits = 6'd4;
      DEP_8:    depth_bits = 6'd8;
      DEP_1555: depth_bits = 6'd16;
      DEP_565:  depth_bits = 6'd16;
      DEP_24:   depth_bits = 6'd24;
      default:  depth_bits = 6'd0;
    endcase
  endfunction

  // Legal code for the given panel type.
  function automatic logic depth_legal(depth_e d, logic tft);
    case (d)
      DEP_RSV1, DEP_RSV7: depth_legal = 1'b0;
      DEP_24:             depth_legal = tft;
      default:            depth_legal = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/lcd_unpack_seq.sv
module lcd_unpack_seq #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ok,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              out_ready,
  output logic              full_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic [WORD_W-1:0] word_q
);

  logic              out_fire;
  logic              at_last;
  logic              in_fire;
  logic              full_n;
  logic              idx_en;
  logic [IDX_W-1:0]  idx_n;
  logic              word_en;

  always_comb begin
    out_fire = full_q && cfg_ok && out_ready;
    at_last  = (idx_q >= last_idx);
    in_ready = cfg_ok && (!full_q || (out_fire && at_last));
    in_fire  = in_valid && in_ready;

    full_n  = full_q;
    idx_en  = 1'b0;
    idx_n   = idx_q;
    word_en = 1'b0;
    if (in_fire) begin
      full_n  = 1'b1;
      word_en = 1'b1;
      idx_en  = 1'b1;
      idx_n   = '0;
    end else if (out_fire && at_last) begin
      full_n = 1'b0;
    end else if (out_fire) begin
      idx_en = 1'b1;
      idx_n  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      idx_q  <= '0;
      word_q <= '0;
    end else begin
      full_q <= full_n;
      if (idx_en)  idx_q  <= idx_n;
      if (word_en) word_q <= in_data;
    end
  end

endmodule

// File: rtl/lcd_unpack_field.sv
module lcd_unpack_field #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5,
  parameter int PIX_W  = 24
) (
  input  logic [WORD_W-1:0]         word_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [$clog2(WORD_W):0]   bpp_i,
  input  logic                      byte_be_i,
  input  logic                      pix_msb_i,
  input  logic                      whole_i,
  output logic [PIX_W-1:0]          raw_o
);

  localparam int BYTES = WORD_W / 8;
  localparam int SH_W  = $clog2(WORD_W) + 1;

  logic [WORD_W-1:0] swapped;
  logic [WORD_W-1:0] ordered;
  logic [SH_W-1:0]   lo_pos;
  logic [SH_W-1:0]   hi_pos;
  logic [SH_W-1:0]   shift;
  logic [WORD_W-1:0] shifted;
  logic [WORD_W-1:0] mask;

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    assign swapped[g*8 +: 8] = word_i[(BYTES-1-g)*8 +: 8];
  end

  always_comb begin
    ordered = byte_be_i ? swapped : word_i;
    lo_pos  = SH_W'(idx_i) * bpp_i;
    hi_pos  = SH_W'(WORD_W) - lo_pos - bpp_i;
    if (whole_i)        shift = '0;
    else if (pix_msb_i) shift = hi_pos;
    else                shift = lo_pos;
    shifted = ordered >> shift;
    mask    = ~({WORD_W{1'b1}} << bpp_i);
    raw_o   = PIX_W'(shifted & mask);
  end

endmodule

// File: rtl/lcd_unpack_color.sv
module lcd_unpack_color
  import lcd_unpack_pkg::*;
(
  input  logic [23:0] raw_i,
  input  depth_e      depth_i,
  input  logic        bgr_i,
  output logic [23:0] pix_o
);

  logic [7:0] red;
  logic [7:0] grn;
  logic [7:0] blu;
  logic       is_rgb;

  always_comb begin
    red    = '0;
    grn    = '0;
    blu    = '0;
    is_rgb = 1'b1;
    case (depth_i)
      DEP_1555: begin
        red = {raw_i[14:10], raw_i[14:12]};
        grn = {raw_i[9:5],   raw_i[9:7]};
        blu = {raw_i[4:0],   raw_i[4:2]};
      end
      DEP_565: begin
        red = {raw_i[15:11], raw_i[15:13]};
        grn = {raw_i[10:5],  raw_i[10:9]};
        blu = {raw_i[4:0],   raw_i[4:2]};
      end
      DEP_24: begin
        red = raw_i[23:16];
        grn = raw_i[15:8];
        blu = raw_i[7:0];
      end
      default: is_rgb = 1'b0;
    endcase

    if (!is_rgb)    pix_o = raw_i;
    else if (bgr_i) pix_o = {blu, grn, red};
    else            pix_o = {red, grn, blu};
  end

endmodule

// File: rtl/lcd_pix_unpack.sv
module lcd_pix_unpack
  import lcd_unpack_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_depth,
  input  logic              cfg_tft,
  input  logic              cfg_byte_be,
  input  logic              cfg_pix_msb,
  input  logic              cfg_bgr,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_pixel,
  input  logic              out_ready,
  output logic              cfg_err
);

  localparam int IDX_W = $clog2(WORD_W);
  localparam int SH_W  = IDX_W + 1;

  depth_e             depth;
  logic               cfg_ok;
  logic [SH_W-1:0]    bpp;
  logic [IDX_W-1:0]   last_idx;
  logic               whole;
  logic               full_q;
  logic [IDX_W-1:0]   idx_q;
  logic [WORD_W-1:0]  word_q;
  logic [PIX_W-1:0]   raw;

  always_comb begin
    depth  = depth_e'(cfg_depth);
    cfg_ok = depth_legal(depth, cfg_tft);
    bpp    = SH_W'(depth_bits(depth));
    whole  = (depth == DEP_24);
    case (depth)
      DEP_1:             last_idx = IDX_W'(WORD_W - 1);
      DEP_4:             last_idx = IDX_W'(WORD_W / 4 - 1);
      DEP_8:             last_idx = IDX_W'(WORD_W / 8 - 1);
      DEP_1555, DEP_565: last_idx = IDX_W'(WORD_W / 16 - 1);
      default:           last_idx = '0;
    endcase
    cfg_err   = !cfg_ok;
    out_valid = full_q && cfg_ok;
  end

  lcd_unpack_seq #(.WORD_W(WORD_W), .IDX_W(IDX_W)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_ok   (cfg_ok),
    .last_idx (last_idx),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .out_ready(out_ready),
    .full_q   (full_q),
    .idx_q    (idx_q),
    .word_q   (word_q)
  );

  lcd_unpack_field #(.WORD_W(WORD_W), .IDX_W(IDX_W), .PIX_W(PIX_W)) i_field (
    .word_i   (word_q),
    .idx_i    (idx_q),
    .bpp_i    (bpp),
    .byte_be_i(cfg_byte_be),
    .pix_msb_i(cfg_pix_msb),
    .whole_i  (whole),
    .raw_o    (raw)
  );

  lcd_unpack_color i_color (
    .raw_i  (raw[23:0]),
    .depth_i(depth),
    .bgr_i  (cfg_bgr),
    .pix_o  (out_pixel)
  );

endmodule

// File: rtl/lcd_pix_unpack_chk.sv
module lcd_pix_unpack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  cfg_depth,
  input logic        cfg_tft,
  input logic        cfg_byte_be,
  input logic        cfg_pix_msb,
  input logic        cfg_bgr,
  input logic        in_ready,
  input logic        out_valid,
  input logic [23:0] out_pixel,
  input logic        out_ready,
  input logic        cfg_err
);

  logic [6:0] cfg_all;
  assign cfg_all = {cfg_depth, cfg_tft, cfg_byte_be, cfg_pix_msb, cfg_bgr};

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!in_ready && !out_valid)); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (!$stable(cfg_all) || (out_valid && $stable(out_pixel)))); // R10

  AST_TAKE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && out_valid) |-> out_ready); // R10

  AST_INDEX_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_depth == 3'b011) |-> (out_pixel[23:8] == 16'd0)); // R5

  AST_565_WIDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_depth == 3'b110) |->
      (out_pixel[2:0] == out_pixel[7:5] && out_pixel[18:16] == out_pixel[23:21]
       && out_pixel[9:8] == out_pixel[15:14])); // R6

  AST_1555_WIDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_depth == 3'b100) |->
      (out_pixel[2:0] == out_pixel[7:5] && out_pixel[18:16] == out_pixel[23:21]
       && out_pixel[10:8] == out_pixel[15:13])); // R7

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_EMPTY: assert (!out_valid); // R11
    end
  end

endmodule

bind lcd_pix_unpack lcd_pix_unpack_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_depth  (cfg_depth),
  .cfg_tft    (cfg_tft),
  .cfg_byte_be(cfg_byte_be),
  .cfg_pix_msb(cfg_pix_msb),
  .cfg_bgr    (cfg_bgr),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_pixel  (out_pixel),
  .out_ready  (out_ready),
  .cfg_err    (cfg_err)
);

// File: tb/test_lcd_pix_unpack.sv
module test_lcd_pix_unpack;

  logic        clk;
  logic        rst_n;
  logic [2:0]  cfg_depth;
  logic        cfg_tft;
  logic        cfg_byte_be;
  logic        cfg_pix_msb;
  logic        cfg_bgr;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_ready;
  logic        out_valid;
  logic [23:0] out_pixel;
  logic        out_ready;
  logic        cfg_err;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] lfsr = 32'h1234_5678;
  bit done = 0;

  lcd_pix_unpack i_lcd_pix_unpack (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_tft(cfg_tft),
    .cfg_byte_be(cfg_byte_be), .cfg_pix_msb(cfg_pix_msb), .cfg_bgr(cfg_bgr),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_pixel(out_pixel), .out_ready(out_ready),
    .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int bpp_of(bit [2:0] d);
    case (d)
      3'b000: return 1;
      3'b010: return 4;
      3'b011: return 8;
      3'b101: return 24;
      default: return 16;
    endcase
  endfunction

  function automatic int ppw_of(bit [2:0] d);
    return (d == 3'b101) ? 1 : 32 / bpp_of(d);
  endfunction

  function automatic logic [23:0] exp_pix(logic [31:0] w, int k, bit [2:0] d,
                                          bit be, bit msb, bit bgr);
    logic [31:0] o;
    longint f;
    int bpp, pos, r, g, b;
    o   = be ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    bpp = bpp_of(d);
    if (d == 3'b101) f = longint'(o) & 64'hFF_FFFF;
    else begin
      pos = msb ? 32 - (k + 1) * bpp : k * bpp;
      f   = (longint'(o) >> pos) & ((64'd1 << bpp) - 1);
    end
    case (d)
      3'b100: begin
        r = int'((f >> 10) & 31); g = int'((f >> 5) & 31); b = int'(f & 31);
        r = r * 8 + r / 4; g = g * 8 + g / 4; b = b * 8 + b / 4;
      end
      3'b110: begin
        r = int'((f >> 11) & 31); g = int'((f >> 5) & 63); b = int'(f & 31);
        r = r * 8 + r / 4; g = g * 4 + g / 16; b = b * 8 + b / 4;
      end
      3'b101: begin
        r = int'((f >> 16) & 255); g = int'((f >> 8) & 255); b = int'(f & 255);
      end
      default: return 24'(f);
    endcase
    if (bgr) return 24'(b * 65536 + g * 256 + r);
    return 24'(r * 65536 + g * 256 + b);
  endfunction

  function automatic string tag_of(bit [2:0] d);
    case (d)
      3'b100: return "R7";
      3'b110: return "R6";
      3'b101: return "R8";
      default: return "R5";
    endcase
  endfunction

  // Called at a negedge; returns at a negedge.
  task automatic run(bit [2:0] d, bit be, bit msb, bit bgr, int nw, bit stall);
    logic [31:0] wq[$];
    logic [23:0] expq[$];
    logic [23:0] hold_pix;
    bit hold_pend = 0;
    bit started = 0;
    bit bubble = 0;
    int sent = 0;
    int cyc = 0;
    cfg_depth = d; cfg_tft = 1'b1; cfg_byte_be = be; cfg_pix_msb = msb; cfg_bgr = bgr;
    for (int i = 0; i < nw; i++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      wq.push_back(lfsr);
      for (int k = 0; k < ppw_of(d); k++) expq.push_back(exp_pix(lfsr, k, d, be, msb, bgr));
    end
    while (expq.size() > 0 && cyc < 6000) begin
      in_valid  = (sent < nw) && !(stall && (cyc % 5 == 2));
      in_data   = (sent < nw) ? wq[sent] : 32'h0;
      out_ready = stall ? (cyc % 3 != 1) : 1'b1;
      #1;
      if (hold_pend) begin
        chk(out_valid && out_pixel == hold_pix, "R10", "stalled pixel held",
            {8'h0, out_pixel}, {8'h0, hold_pix});
        hold_pend = 0;
      end
      if (!stall && started && !out_valid) bubble = 1;
      if (out_valid && out_ready) begin
        chk(out_pixel == expq[0], tag_of(d),
            $sformatf("pixel d=%b be=%0b msb=%0b bgr=%0b (R3/R4/R9 order and swap)", d, be, msb, bgr),
            {8'h0, out_pixel}, {8'h0, expq[0]});
        void'(expq.pop_front());
        started = 1;
      end else if (out_valid) begin
        hold_pix  = out_pixel;
        hold_pend = 1;
      end
      if (in_valid && in_ready) sent++;
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0;
    #1;
    chk(expq.size() == 0 && sent == nw && !out_valid, "R1", "pixel count per word",
        32'(expq.size()), 32'h0);
    if (!stall) chk(!bubble, "R10", "gap-free stream", 32'(bubble), 32'h0);
  endtask

  task automatic err_cycle(bit [2:0] d, bit tft, string what);
    cfg_depth = d; cfg_tft = tft; in_valid = 1'b1; in_data = 32'hA5A5_5A5A; out_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(cfg_err && !in_ready && !out_valid, "R2", what,
          {29'h0, cfg_err, in_ready, out_valid}, 32'h4);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    finish_up();
  end

  initial begin
    bit [2:0] modes [6];
    modes = '{3'b000, 3'b010, 3'b011, 3'b100, 3'b110, 3'b101};
    rst_n = 1'b0; cfg_depth = 3'b011; cfg_tft = 1'b0; cfg_byte_be = 1'b0;
    cfg_pix_msb = 1'b0; cfg_bgr = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    @(negedge clk);
    #1;
    chk(!out_valid, "R11", "out_valid in reset", 32'(out_valid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!out_valid && in_ready && !cfg_err, "R11", "idle after reset",
        {29'h0, out_valid, in_ready, cfg_err}, 32'h2);
    @(negedge clk);

    // Illegal codes with nothing held.
    err_cycle(3'b001, 1'b1, "code 001");
    err_cycle(3'b111, 1'b1, "code 111");
    err_cycle(3'b101, 1'b0, "24-bit without panel-type bit");

    // Illegal code while a word is held: hold, then resume.
    cfg_depth = 3'b011; cfg_tft = 1'b0; cfg_byte_be = 0; cfg_pix_msb = 0; cfg_bgr = 0;
    in_valid = 1'b1; in_data = 32'h1122_3344; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    #1;
    chk(out_valid && out_pixel == 24'h44, "R3", "first byte little-endian",
        {8'h0, out_pixel}, 32'h44);
    @(negedge clk);
    err_cycle(3'b111, 1'b0, "code 111 while holding");
    cfg_depth = 3'b011;
    for (int k = 1; k < 4; k++) begin
      #1;
      chk(out_valid && out_pixel == 24'(8'h44 >> 0 == 0 ? 0 : (32'h1122_3344 >> (8 * k)) & 255),
          "R2", "resumed pixel", {8'h0, out_pixel}, (32'h1122_3344 >> (8 * k)) & 255);
      @(negedge clk);
    end
    #1;
    chk(!out_valid, "R2", "word drained after resume", 32'(out_valid), 32'h0);
    @(negedge clk);

    // Full sweep of legal modes and order controls.
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 6; m++)
        for (int c = 0; c < 8; c++)
          run(modes[m], c[2], c[1], c[0], 4, s[0]);

    finish_up();
  end

endmodule